// File: doc/BRIEF.md
# Host Command and Semaphore Register Block

This block is the register window that a host processor sees on a communications controller. It decodes byte addresses from a host bus that can run 8 or 16 bits wide. Behind it sit four registers:

- a command port that can only be written;
- a semaphore byte that can only be read, sharing the command port's address;
- an interrupt vector byte;
- a 32-bit data register split into four bytes.

A command written by the host becomes a one-cycle strobe, carrying the opcode, toward an internal command executor. The executor reports completion back on a done pulse. It also reports interrupts on a raise pulse with a severity flag.

The semaphore is the host's handshake. It reads 0xFE once a command has been taken. It reads 0xFF once a reset-class command has finished. The host programs the upper six bits of the interrupt vector, and the block fills the two low bits with a cause code. During an interrupt-acknowledge cycle the block drives that vector onto the bus.

The bus starts 8 bits wide, and each register byte then has its own address. The load-function-code command (opcodes 0xD0 and 0xD1) selects the width when it completes. In 16-bit mode a word access uses an upper and a lower byte strobe.

Top module: `host_reg_if`

## Requirements
- R1: After reset the semaphore reads 0xFF, the vector reads 0x0F, the data register is zero, the bus is 8 bits wide (`wideBus`=0) and `cmdValid` is low.
- R2: A host write to the command port drives `cmdValid` high for exactly one cycle, in the cycle after the write, with `cmdCode` equal to the written byte. Every opcode is accepted, including 0xFF, whether the semaphore reads 0xFE or 0xFF. The command port is byte address 1 in 8-bit mode, and the lower lane of word offset 0 in 16-bit mode.
- R3: A read at the command port address returns the semaphore. The semaphore reads 0xFE from the cycle after any command write.
- R4: The semaphore changes to 0xFF only on a `cmdDone` pulse while the last accepted opcode is 0xFF, 0xD0 or 0xD1. A `cmdDone` pulse after any other opcode leaves it at 0xFE.
- R5: The vector reads 0x0F until the host first writes it (byte address 3, or the lower lane of word offset 2). After that it reads the written bits 7..2 followed by the cause code. The host's bits 1..0 are ignored.
- R6: An `irqRaise` pulse stores the cause code 01 when `irqSevere` is high and 00 otherwise. The stored code appears in vector bits 1..0 from the next cycle.
- R7: While `intAck` is high, `busRdata` carries the vector in bits 7..0 and zero in bits 15..8.
- R8: The data register bytes map as follows. In 8-bit mode, addresses 4, 5, 6 and 7 hold bytes 3, 2, 1 and 0 (byte 0 is bits 7..0). In 16-bit mode, offset 4 holds byte 3 on the upper lane and byte 2 on the lower lane, and offset 6 holds byte 1 upper and byte 0 lower.
- R9: In 16-bit mode, `busUds` writes bits 15..8 to the even byte and `busLds` writes bits 7..0 to the odd byte. A lane without its strobe is left unchanged, and a command write without `busLds` issues no command.
- R10: On a `cmdDone` that completes 0xD0 or 0xD1, `wideBus` takes opcode bit 0. A write of opcode 0xFF returns `wideBus` to 0 in the next cycle. Nothing else changes `wideBus`.
- R11: In 8-bit mode each access moves one byte on bits 7..0, and read data has bits 15..8 at zero. Addresses 0 and 2 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Host access this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Byte address; bits 2..1 select the word in 16-bit mode |
| busUds | input | 1 | Upper byte strobe (16-bit mode) |
| busLds | input | 1 | Lower byte strobe (16-bit mode) |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, combinational |
| intAck | input | 1 | Interrupt-acknowledge cycle |
| cmdValid | output | 1 | One-cycle command strobe |
| cmdCode | output | 8 | Opcode accompanying the strobe |
| cmdDone | input | 1 | Executor completion pulse |
| irqRaise | input | 1 | Executor raises an interrupt |
| irqSevere | input | 1 | Raised interrupt is the severe kind |
| dataReg | output | 32 | Data register contents |
| wideBus | output | 1 | 1 = 16-bit host bus |

## Verification
Read data and the acknowledge vector are combinational, so they are sampled 1 ns after the address is applied at a falling edge. Register effects appear one clock after the edge that captured them:

- the semaphore value, vector bits, data bytes and `wideBus` are checked at the falling edge after the write, done or raise edge;
- `cmdValid` is due in that same cycle and is gone one edge later.

Each command write pushes its opcode into a scoreboard queue. A monitor pops the queue at every falling edge where the strobe is high, so a missing, extra or repeated strobe shows up as a mismatch or as entries left in the queue at the end.

// File: rtl/hif_pkg.sv
package hif_pkg;
  localparam int BYTE_W   = 8;
  localparam int BUS_W    = 2 * BYTE_W;
  localparam int SLOT_N   = 8;
  localparam int SLOT_AW  = $clog2(SLOT_N);
  localparam int DR_BYTES = 4;
  localparam int DR_W     = DR_BYTES * BYTE_W;
  localparam int CR_SLOT  = 1;
  localparam int IV_SLOT  = 3;
  localparam int DR_SLOT0 = 4;

  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t OP_RESET  = 8'hFF;
  localparam byte_t OP_LOADFC = 8'hD0;
  localparam byte_t SEM_BUSY  = 8'hFE;
  localparam byte_t SEM_READY = 8'hFF;
  localparam byte_t IV_RESET  = 8'h0F;

  typedef enum logic [1:0] {PEND_NONE, PEND_RESET, PEND_LOADFC} pend_e;

  typedef struct packed {
    logic [SLOT_N-1:0] slotWe;
    logic              causeLoad;
    logic              causeSevere;
  } strobes_t;
endpackage

// File: rtl/hif_ctrl.sv
module hif_ctrl
  import hif_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          busSel,
  input  logic                          busWr,
  input  logic [SLOT_AW-1:0]            busAddr,
  input  logic                          busUds,
  input  logic                          busLds,
  input  logic [BUS_W-1:0]              busWdata,
  input  logic                          cmdDone,
  input  logic                          irqRaise,
  input  logic                          irqSevere,
  output strobes_t                      strb,
  output logic [SLOT_N-1:0][BYTE_W-1:0] slotData,
  output byte_t                         semByte,
  output logic                          wideBus,
  output logic                          cmdValid,
  output byte_t                         cmdCode
);
  logic [SLOT_N-1:0] slotWe;
  logic              wideQ;
  logic              pendWidthQ;
  logic              cmdValidQ;
  logic              crWr;
  logic              isLoadFc;
  byte_t             semQ;
  byte_t             cmdCodeQ;
  byte_t             crByte;
  pend_e             pendQ;

  // Byte-slot decode: narrow mode hits one slot per address, wide mode two lanes
  for (genvar s = 0; s < SLOT_N; s++) begin : g_slot
    localparam bit ODD = (s % 2) == 1;
    logic narrowHit;
    logic wideHit;
    assign narrowHit   = busAddr == SLOT_AW'(s);
    assign wideHit     = (busAddr[SLOT_AW-1:1] == (SLOT_AW-1)'(s / 2)) && (ODD ? busLds : busUds);
    assign slotWe[s]   = busSel && busWr && (wideQ ? wideHit : narrowHit);
    assign slotData[s] = (wideQ && !ODD) ? busWdata[BUS_W-1:BYTE_W] : busWdata[BYTE_W-1:0];
  end

  assign crWr     = slotWe[CR_SLOT];
  assign crByte   = slotData[CR_SLOT];
  assign isLoadFc = crByte[BYTE_W-1:1] == OP_LOADFC[BYTE_W-1:1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      semQ       <= SEM_READY;
      wideQ      <= 1'b0;
      pendWidthQ <= 1'b0;
      pendQ      <= PEND_NONE;
      cmdValidQ  <= 1'b0;
      cmdCodeQ   <= '0;
    end else begin
      cmdValidQ <= crWr;
      if (crWr) begin
        cmdCodeQ <= crByte;
        semQ     <= SEM_BUSY;
        if (crByte == OP_RESET) begin
          pendQ <= PEND_RESET;
          wideQ <= 1'b0;
        end else if (isLoadFc) begin
          pendQ      <= PEND_LOADFC;
          pendWidthQ <= crByte[0];
        end else begin
          pendQ <= PEND_NONE;
        end
      end else if (cmdDone && pendQ != PEND_NONE) begin
        semQ  <= SEM_READY;
        pendQ <= PEND_NONE;
        if (pendQ == PEND_LOADFC) wideQ <= pendWidthQ;
      end
    end
  end

  assign strb.slotWe      = slotWe;
  assign strb.causeLoad   = irqRaise;
  assign strb.causeSevere = irqSevere;
  assign semByte          = semQ;
  assign wideBus          = wideQ;
  assign cmdValid         = cmdValidQ;
  assign cmdCode          = cmdCodeQ;

  // R3
  sem_busy_after_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    crWr |=> semQ == SEM_BUSY);
  // R2
  strobe_follows_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValidQ |-> $past(crWr));
  // R4
  sem_ready_needs_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (semQ == SEM_READY && $past(semQ) != SEM_READY) |-> $past(cmdDone));
  // R10
  width_change_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wideQ) |-> ($past(cmdDone) || $past(crWr)));
  // R11
  narrow_single_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wideQ |-> $onehot0(slotWe));
endmodule

// File: rtl/hif_dpath.sv
module hif_dpath
  import hif_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  strobes_t                      strb,
  input  logic [SLOT_N-1:0][BYTE_W-1:0] slotData,
  input  byte_t                         semByte,
  input  logic                          wideBus,
  input  logic                          busSel,
  input  logic                          busWr,
  input  logic [SLOT_AW-1:0]            busAddr,
  input  logic                          intAck,
  output logic [BUS_W-1:0]              busRdata,
  output logic [DR_W-1:0]               dataReg
);
  localparam int HOST_W = BYTE_W - 2;

  logic [HOST_W-1:0]             ivHostQ;
  logic                          ivWrittenQ;
  logic [1:0]                    causeQ;
  byte_t                         vecByte;
  logic [SLOT_N-1:0][BYTE_W-1:0] rdSlot;
  logic [SLOT_AW-1:0]            evenIx;
  logic [SLOT_AW-1:0]            oddIx;

  // Data register: byte b lives in slot DR_SLOT0 + (DR_BYTES-1-b)
  for (genvar b = 0; b < DR_BYTES; b++) begin : g_dr
    localparam int SLOT = DR_SLOT0 + DR_BYTES - 1 - b;
    byte_t byteQ;
    always_ff @(posedge clk) begin
      if (!rstN) byteQ <= '0;
      else if (strb.slotWe[SLOT]) byteQ <= slotData[SLOT];
    end
    assign dataReg[b*BYTE_W +: BYTE_W] = byteQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ivHostQ    <= '0;
      ivWrittenQ <= 1'b0;
      causeQ     <= 2'b00;
    end else begin
      if (strb.slotWe[IV_SLOT]) begin
        ivHostQ    <= slotData[IV_SLOT][BYTE_W-1:2];
        ivWrittenQ <= 1'b1;
      end
      if (strb.causeLoad) causeQ <= {1'b0, strb.causeSevere};
    end
  end

  assign vecByte = ivWrittenQ ? {ivHostQ, causeQ} : IV_RESET;

  for (genvar s = 0; s < SLOT_N; s++) begin : g_rd
    if (s == CR_SLOT) begin : g_sem
      assign rdSlot[s] = semByte;
    end else if (s == IV_SLOT) begin : g_iv
      assign rdSlot[s] = vecByte;
    end else if (s >= DR_SLOT0 && s < DR_SLOT0 + DR_BYTES) begin : g_drr
      assign rdSlot[s] = dataReg[(DR_SLOT0 + DR_BYTES - 1 - s)*BYTE_W +: BYTE_W];
    end else begin : g_zero
      assign rdSlot[s] = '0;
    end
  end

  assign evenIx = {busAddr[SLOT_AW-1:1], 1'b0};
  assign oddIx  = {busAddr[SLOT_AW-1:1], 1'b1};

  always_comb begin
    busRdata = '0;
    if (intAck) begin
      busRdata = {{BYTE_W{1'b0}}, vecByte};
    end else if (busSel && !busWr) begin
      if (wideBus) busRdata = {rdSlot[evenIx], rdSlot[oddIx]};
      else         busRdata = {{BYTE_W{1'b0}}, rdSlot[busAddr]};
    end
  end

  // R6
  cause_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ivWrittenQ && strb.causeLoad) |=> vecByte[1:0] == {1'b0, $past(strb.causeSevere)});
  // R5
  vector_default_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ivWrittenQ |-> vecByte == IV_RESET);
  // R7
  ack_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    intAck |-> busRdata[BUS_W-1:BYTE_W] == '0);
  // R8
  dr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.slotWe[DR_SLOT0 + DR_BYTES - 1:DR_SLOT0] == '0) |=> $stable(dataReg));
endmodule

// File: rtl/host_reg_if.sv
module host_reg_if
  import hif_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [SLOT_AW-1:0] busAddr,
  input  logic               busUds,
  input  logic               busLds,
  input  logic [BUS_W-1:0]   busWdata,
  output logic [BUS_W-1:0]   busRdata,
  input  logic               intAck,
  output logic               cmdValid,
  output logic [BYTE_W-1:0]  cmdCode,
  input  logic               cmdDone,
  input  logic               irqRaise,
  input  logic               irqSevere,
  output logic [DR_W-1:0]    dataReg,
  output logic               wideBus
);
  strobes_t                      strb;
  logic [SLOT_N-1:0][BYTE_W-1:0] slotData;
  byte_t                         semByte;

  hif_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busUds(busUds), .busLds(busLds), .busWdata(busWdata), .cmdDone(cmdDone),
    .irqRaise(irqRaise), .irqSevere(irqSevere), .strb(strb), .slotData(slotData),
    .semByte(semByte), .wideBus(wideBus), .cmdValid(cmdValid), .cmdCode(cmdCode)
  );

  hif_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .slotData(slotData), .semByte(semByte),
    .wideBus(wideBus), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .intAck(intAck), .busRdata(busRdata), .dataReg(dataReg)
  );
endmodule

// File: tb/host_reg_if_tb.sv
module host_reg_if_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0, busUds = 1'b0, busLds = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        intAck = 1'b0, cmdDone = 1'b0, irqRaise = 1'b0, irqSevere = 1'b0;
  logic        cmdValid, wideBus;
  logic [7:0]  cmdCode;
  logic [31:0] dataReg;

  int nChecks = 0;
  int nErr = 0;
  logic [7:0] expQ[$];

  always #2 clk = ~clk;

  host_reg_if u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busUds(busUds), .busLds(busLds), .busWdata(busWdata), .busRdata(busRdata),
    .intAck(intAck), .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdDone(cmdDone),
    .irqRaise(irqRaise), .irqSevere(irqSevere), .dataReg(dataReg), .wideBus(wideBus)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops expected opcodes as strobes appear (R2)
  always @(negedge clk) begin
    if (rstN && cmdValid) begin
      if (expQ.size() == 0) chk("R2 unexpected strobe", {24'h0, cmdCode}, 32'hxxxx_xxxx);
      else chk("R2 strobe opcode", {24'h0, cmdCode}, {24'h0, expQ.pop_front()});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic u, input logic l);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d; busUds = u; busLds = l;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busUds = 1'b0; busLds = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 v = busRdata;
    busSel = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] op, input logic wide);
    expQ.push_back(op);
    if (wide) wr(3'd0, {8'h00, op}, 1'b0, 1'b1);
    else      wr(3'd1, {8'h00, op}, 1'b0, 1'b0);
  endtask

  task automatic pulseDone();
    @(negedge clk); cmdDone = 1'b1;
    @(negedge clk); cmdDone = 1'b0;
  endtask

  task automatic pulseIrq(input logic sev);
    @(negedge clk); irqRaise = 1'b1; irqSevere = sev;
    @(negedge clk); irqRaise = 1'b0; irqSevere = 1'b0;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nErr++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd(3'd1, v); chk("R1 semaphore", {16'h0, v}, 32'h0000_00FF);
    rd(3'd3, v); chk("R1 vector", {16'h0, v}, 32'h0000_000F);
    chk("R1 data reg", dataReg, 32'h0);
    chk("R1 width", {31'h0, wideBus}, 32'h0);
    chk("R1 strobe idle", {31'h0, cmdValid}, 32'h0);
    // R11 even addresses read zero
    rd(3'd0, v); chk("R11 addr0 zero", {16'h0, v}, 32'h0);

    // R5 vector holds 0x0F before first host write even after an interrupt
    pulseIrq(1'b1);
    rd(3'd3, v); chk("R5 vector default kept", {16'h0, v}, 32'h0000_000F);
    wr(3'd3, 16'h0043, 1'b0, 1'b0);
    rd(3'd3, v); chk("R5 R6 host bits with severe cause", {16'h0, v}, 32'h0000_0041);
    pulseIrq(1'b0);
    rd(3'd3, v); chk("R6 normal cause", {16'h0, v}, 32'h0000_0040);
    // R7 acknowledge drives vector
    @(negedge clk); intAck = 1'b1;
    #1 chk("R7 ack vector", {16'h0, busRdata}, 32'h0000_0040);
    intAck = 1'b0;

    // R3 R4 ordinary command stays busy after done
    cmd(8'hC7, 1'b0);
    rd(3'd1, v); chk("R3 busy after command", {16'h0, v}, 32'h0000_00FE);
    pulseDone();
    rd(3'd1, v); chk("R4 ordinary done stays busy", {16'h0, v}, 32'h0000_00FE);
    // R2 reset command accepted while busy
    cmd(8'hFF, 1'b0);
    rd(3'd1, v); chk("R3 busy after reset cmd", {16'h0, v}, 32'h0000_00FE);
    pulseDone();
    rd(3'd1, v); chk("R4 reset done ready", {16'h0, v}, 32'h0000_00FF);

    // R8 narrow data register map
    wr(3'd4, 16'h0011, 1'b0, 1'b0);
    wr(3'd5, 16'h0022, 1'b0, 1'b0);
    wr(3'd6, 16'h0033, 1'b0, 1'b0);
    wr(3'd7, 16'h0044, 1'b0, 1'b0);
    chk("R8 narrow map", dataReg, 32'h1122_3344);
    rd(3'd6, v); chk("R11 narrow read byte1", {16'h0, v}, 32'h0000_0033);

    // R10 width set only at completion
    cmd(8'hD1, 1'b0);
    chk("R10 width before done", {31'h0, wideBus}, 32'h0);
    pulseDone();
    chk("R10 width after done", {31'h0, wideBus}, 32'h1);
    rd(3'd1, v); chk("R4 load done ready", {16'h0, v}, 32'h0000_00FF);

    // R8 R9 wide lanes
    wr(3'd4, 16'hAABB, 1'b1, 1'b1);
    chk("R8 wide offset4", dataReg, 32'hAABB_3344);
    wr(3'd6, 16'hCCDD, 1'b1, 1'b0);
    chk("R9 upper lane only", dataReg, 32'hAABB_CC44);
    rd(3'd4, v); chk("R8 wide read offset4", {16'h0, v}, 32'h0000_AABB);
    rd(3'd0, v); chk("R3 wide semaphore read", {16'h0, v}, 32'h0000_00FF);
    rd(3'd2, v); chk("R5 wide vector read", {16'h0, v}, 32'h0000_0040);
    // R9 command lane without lower strobe ignored
    wr(3'd0, 16'h00C7, 1'b1, 1'b0);
    rd(3'd0, v); chk("R9 no command without lower strobe", {16'h0, v}, 32'h0000_00FF);
    cmd(8'hF0, 1'b1);
    rd(3'd0, v); chk("R2 wide command busy", {16'h0, v}, 32'h0000_00FE);
    // R10 reset command returns to narrow at once
    cmd(8'hFF, 1'b1);
    chk("R10 reset narrows", {31'h0, wideBus}, 32'h0);
    pulseDone();
    rd(3'd1, v); chk("R4 reset done narrow read", {16'h0, v}, 32'h0000_00FF);
    cmd(8'hD0, 1'b0);
    pulseDone();
    chk("R10 load keeps narrow", {31'h0, wideBus}, 32'h0);

    repeat (2) @(negedge clk);
    chk("R2 all strobes seen", expQ.size(), 32'd0);
    finishRun();
  end
endmodule